// File: doc/BRIEF.md
# Compressed Line Coherency Tracker

This block keeps two status bits for every line of the display: a dirty bit and a valid bit, held in on-chip registers. Each time the refresh engine fetches a line, the block states whether that line should come from the uncompressed frame buffer or from the compressed copy kept in off-screen memory. When a line has been fetched uncompressed and the compressor then reports a successful result for it, the block grants a write-back and marks the line valid and clean. From then on the line is served from the compressed copy until a host write marks it dirty again.

A programmable run of static frames can follow each normal frame. During a static frame the dirty bits are ignored and only the valid bits choose the source. The screen content then updates less often than the panel refreshes, while host writes are still recorded. A host write to a line between its uncompressed fetch and its compression result, or in the same cycle as the result, cancels that write-back.

Top module: `line_coherency_tracker`

## Requirements
- R1: After reset every line is invalid and dirty. `fetch_vld` and `wb_en` are 0, and the first fetch of any line selects the frame buffer (`fetch_cmp` = 0).
- R2: `fetch_vld` is 1 in exactly the cycle after a cycle with `fetch_req` = 1. In that cycle `fetch_cmp` gives the source: 1 means the compressed buffer and 0 means the frame buffer.
- R3: In a normal frame, a line that is valid and clean is fetched compressed, and a dirty line is fetched from the frame buffer.
- R4: A successful result (`cmp_done` = 1, `cmp_ok` = 1) for a line whose last fetch was uncompressed raises `wb_en` for one cycle, in the cycle after the result. The line then becomes valid and clean and is fetched compressed on every later access until it is written.
- R5: A failed result (`cmp_ok` = 0) gives no write-back and leaves the line's source unchanged.
- R6: A host write (`host_wr` = 1) sets the dirty bit of `host_wr_line`. The next fetch of that line in a normal frame selects the frame buffer.
- R7: A `frame_start` that arrives while the remaining static count is 0 begins a normal frame and loads the count from `static_count`. A `frame_start` that arrives while the count is nonzero begins a static frame and decrements the count. The state after reset is a normal frame with a count of 0.
- R8: During a static frame, a valid line is fetched compressed even if it is dirty, and an invalid line is fetched from the frame buffer.
- R9: Host writes made during static frames are kept. The first fetch of that line in the next normal frame selects the frame buffer.
- R10: A host write to a line after its uncompressed fetch, or in the same cycle as its result, blocks the write-back. `wb_en` stays 0 and the line stays dirty.
- R11: A result for a line with no outstanding uncompressed fetch is ignored. `wb_en` stays 0 and the line stays uncompressed.
- R12: `static_count` is sampled only at the start of a normal frame. Changing it during a static run does not change the length of that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse at the start of each refreshed frame |
| static_count | input | CNT_W | Number of static frames to insert after each normal frame |
| fetch_req | input | 1 | Refresh fetch request for one line |
| fetch_line | input | LW | Line index of the fetch |
| host_wr | input | 1 | Host write hit strobe |
| host_wr_line | input | LW | Line touched by the host write |
| cmp_done | input | 1 | Compression result strobe |
| cmp_ok | input | 1 | 1 when the compression succeeded |
| cmp_line | input | LW | Line the result belongs to |
| fetch_vld | output | 1 | Source decision is valid this cycle |
| fetch_cmp | output | 1 | 1: compressed buffer, 0: frame buffer |
| wb_en | output | 1 | Write the compressed line back |

## Verification
Each result is due exactly one clock edge after its stimulus. `fetch_vld` and `fetch_cmp` follow `fetch_req` by one cycle, and `wb_en` follows `cmp_done` by one cycle. A state change made by a write, a result or a `frame_start` is seen by a fetch issued in the following cycle. The bench drives every input on the falling edge and samples the outputs on the next falling edge, which is after the single register stage. Ordering cases (write then result, write in the same cycle as the result, and a parameter change during a static run) are each built one cycle at a time.

// File: rtl/lct_pkg.sv
package lct_pkg;
    localparam int LCT_LINES = 64;
    localparam int LCT_CNT_W = 4;

    typedef enum logic {
        SRC_FRAME = 1'b0,
        SRC_COMP  = 1'b1
    } src_e;
endpackage

// File: rtl/lct_static_ctr.sv
module lct_static_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic [CNT_W-1:0] static_count,
    output logic             static_now
);
    typedef struct packed {
        logic [CNT_W-1:0] rem;
        logic             stat;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_start) begin
            if (st_q.rem == '0) begin
                st_d.stat = 1'b0;
                st_d.rem  = static_count;
            end else begin
                st_d.stat = 1'b1;
                st_d.rem  = st_q.rem - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign static_now = st_q.stat;

    assert_static_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && st_q.rem != '0) |=> (st_q.stat && st_q.rem == $past(st_q.rem) - 1'b1));

    assert_normal_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && st_q.rem == '0) |=> (!st_q.stat && st_q.rem == $past(static_count)));
endmodule

// File: rtl/lct_line_bits.sv
module lct_line_bits #(
    parameter int LINES = 64,
    localparam int LW = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LW-1:0]    wr_line,
    input  logic             arm_en,
    input  logic [LW-1:0]    arm_line,
    input  logic             res_en,
    input  logic             res_ok,
    input  logic [LW-1:0]    res_line,
    output logic [LINES-1:0] valid_o,
    output logic [LINES-1:0] dirty_o,
    output logic             accept_o
);
    typedef struct packed {
        logic [LINES-1:0] valid;
        logic [LINES-1:0] dirty;
        logic [LINES-1:0] armed;
    } bits_t;

    bits_t st_d, st_q;
    logic  accept;

    always_comb begin
        accept = res_en && res_ok && (int'(res_line) < LINES)
                 && st_q.armed[res_line]
                 && !(wr_en && wr_line == res_line);
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < LINES; i++) begin
            if (wr_en && wr_line == LW'(i)) begin
                st_d.dirty[i] = 1'b1;
                st_d.armed[i] = 1'b0;
            end else if (res_en && res_line == LW'(i)) begin
                st_d.armed[i] = 1'b0;
                if (accept) begin
                    st_d.dirty[i] = 1'b0;
                    st_d.valid[i] = 1'b1;
                end
            end else if (arm_en && arm_line == LW'(i)) begin
                st_d.armed[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.valid <= '0;
            st_q.dirty <= '1;
            st_q.armed <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o  = st_q.valid;
    assign dirty_o  = st_q.dirty;
    assign accept_o = accept;

    assert_write_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> st_q.dirty[$past(wr_line)]);

    assert_accept_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (st_q.valid[$past(res_line)] && !st_q.dirty[$past(res_line)]));
endmodule

// File: rtl/line_coherency_tracker.sv
module line_coherency_tracker
    import lct_pkg::*;
#(
    parameter int LINES = LCT_LINES,
    parameter int CNT_W = LCT_CNT_W,
    localparam int LW = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic [CNT_W-1:0] static_count,
    input  logic             fetch_req,
    input  logic [LW-1:0]    fetch_line,
    input  logic             host_wr,
    input  logic [LW-1:0]    host_wr_line,
    input  logic             cmp_done,
    input  logic             cmp_ok,
    input  logic [LW-1:0]    cmp_line,
    output logic             fetch_vld,
    output logic             fetch_cmp,
    output logic             wb_en
);
    typedef struct packed {
        logic vld;
        src_e src;
        logic wb;
    } out_t;

    out_t             st_d, st_q;
    logic             static_now;
    logic [LINES-1:0] valid_v, dirty_v;
    logic             accept;
    logic             use_comp;
    logic             arm_fetch;

    lct_static_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .static_count (static_count),
        .static_now   (static_now)
    );

    always_comb begin
        use_comp  = (int'(fetch_line) < LINES) && valid_v[fetch_line]
                    && (static_now || !dirty_v[fetch_line]);
        arm_fetch = fetch_req && !use_comp;
    end

    lct_line_bits #(.LINES(LINES)) u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (host_wr),
        .wr_line  (host_wr_line),
        .arm_en   (arm_fetch),
        .arm_line (fetch_line),
        .res_en   (cmp_done),
        .res_ok   (cmp_ok),
        .res_line (cmp_line),
        .valid_o  (valid_v),
        .dirty_o  (dirty_v),
        .accept_o (accept)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = fetch_req;
        st_d.src = (fetch_req && use_comp) ? SRC_COMP : SRC_FRAME;
        st_d.wb  = accept;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{vld: 1'b0, src: SRC_FRAME, wb: 1'b0};
        else        st_q <= st_d;
    end

    assign fetch_vld = st_q.vld;
    assign fetch_cmp = (st_q.src == SRC_COMP);
    assign wb_en     = st_q.wb;

    assert_fetch_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> fetch_vld);

    assert_no_idle_vld_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_req |=> !fetch_vld);

    assert_wb_needs_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> $past(cmp_done && cmp_ok));

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_done && host_wr && host_wr_line == cmp_line) |=> !wb_en);
endmodule

// File: tb/sim_line_coherency_tracker.sv
module sim_line_coherency_tracker;
    localparam int LINES = 64;
    localparam int CNT_W = 4;
    localparam int LW    = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_start = 1'b0;
    logic [CNT_W-1:0] static_count = '0;
    logic             fetch_req = 1'b0;
    logic [LW-1:0]    fetch_line = '0;
    logic             host_wr = 1'b0;
    logic [LW-1:0]    host_wr_line = '0;
    logic             cmp_done = 1'b0;
    logic             cmp_ok = 1'b0;
    logic [LW-1:0]    cmp_line = '0;
    logic             fetch_vld, fetch_cmp, wb_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    line_coherency_tracker #(.LINES(LINES), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .static_count(static_count), .fetch_req(fetch_req),
        .fetch_line(fetch_line), .host_wr(host_wr),
        .host_wr_line(host_wr_line), .cmp_done(cmp_done),
        .cmp_ok(cmp_ok), .cmp_line(cmp_line),
        .fetch_vld(fetch_vld), .fetch_cmp(fetch_cmp), .wb_en(wb_en)
    );

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic fetch(int line, logic exp_cmp, string req);
        fetch_req  = 1'b1;
        fetch_line = LW'(line);
        @(negedge clk);
        fetch_req = 1'b0;
        chk({req, " fetch_vld"}, fetch_vld, 1'b1);
        chk({req, " fetch_cmp"}, fetch_cmp, exp_cmp);
    endtask

    task automatic hwrite(int line);
        host_wr      = 1'b1;
        host_wr_line = LW'(line);
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic result(int line, logic ok, logic exp_wb, string req);
        cmp_done = 1'b1;
        cmp_ok   = ok;
        cmp_line = LW'(line);
        @(negedge clk);
        cmp_done = 1'b0;
        chk({req, " wb_en"}, wb_en, exp_wb);
    endtask

    task automatic frame();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 fetch_vld after reset", fetch_vld, 1'b0);
        chk("R1 wb_en after reset", wb_en, 1'b0);
        fetch(5, 1'b0, "R1");
        @(negedge clk);
        chk("R2 no request no vld", fetch_vld, 1'b0);
    endtask

    task automatic t_compress();
        fetch(3, 1'b0, "R3 dirty line");
        result(3, 1'b1, 1'b1, "R4 write-back");
        @(negedge clk);
        chk("R4 wb pulse single", wb_en, 1'b0);
        fetch(3, 1'b1, "R3 valid clean");
        fetch(3, 1'b1, "R4 stays compressed");
    endtask

    task automatic t_fail();
        fetch(7, 1'b0, "R5 pre");
        result(7, 1'b0, 1'b0, "R5 failed");
        fetch(7, 1'b0, "R5 source unchanged");
    endtask

    task automatic t_write();
        hwrite(3);
        fetch(3, 1'b0, "R6 written line");
        result(3, 1'b1, 1'b1, "R6 recompress");
        fetch(3, 1'b1, "R6 compressed again");
    endtask

    task automatic t_race();
        fetch(10, 1'b0, "R10 pre");
        hwrite(10);
        result(10, 1'b1, 1'b0, "R10 write before result");
        fetch(10, 1'b0, "R10 stays dirty");
        fetch(11, 1'b0, "R10 pre same");
        host_wr = 1'b1;
        host_wr_line = LW'(11);
        result(11, 1'b1, 1'b0, "R10 same-cycle write");
        host_wr = 1'b0;
        fetch(11, 1'b0, "R10 same-cycle stays dirty");
    endtask

    task automatic t_stray();
        result(20, 1'b1, 1'b0, "R11 stray result");
        fetch(20, 1'b0, "R11 still uncompressed");
    endtask

    task automatic t_static();
        static_count = 4'd2;
        frame();
        hwrite(3);
        fetch(3, 1'b0, "R3 dirty in normal frame");
        frame();
        fetch(3, 1'b1, "R8 valid dirty in static");
        fetch(7, 1'b0, "R8 invalid in static");
        hwrite(3);
        static_count = 4'd5;
        frame();
        fetch(3, 1'b1, "R7 second static frame");
        frame();
        fetch(3, 1'b0, "R9 R12 normal after two static");
        for (int k = 0; k < 5; k++) begin
            frame();
            fetch(3, 1'b1, "R7 reloaded static run");
        end
        static_count = 4'd0;
        frame();
        fetch(3, 1'b0, "R7 normal after run");
        frame();
        fetch(3, 1'b0, "R7 zero count stays normal");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_compress();
        t_fail();
        t_write();
        t_race();
        t_stray();
        t_static();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule